// File: doc/BRIEF.md
# Edge-Selectable Masked Interrupt Controller

This block gathers alarm and event indications from a line interface and condenses them into a single interrupt pin. Two kinds of source are handled. Level sources carry a real-time condition: loss of signal, alarm indication, driver failure, transmit clock loss, pattern sync, in-band loop-up code and in-band loop-down code. Pulse sources are one-cycle strobes: pattern error, code violation, excess zeros, jitter FIFO overflow and underflow, one-second tick, error counter overflow and waveform DAC overflow.

Each level source is sampled into a status register. A per-source edge-select bit decides whether only a rise, or any change, of that registered status sets a sticky latched bit. Pulse strobes set their latched bits directly. Each latched bit stays set until the host clears it by writing a 1 to its position. Per-source mask bits decide which latched bits reach the pin. The pin can be configured as an open-drain active-low output, a push-pull active-low output or a push-pull active-high output. A small address/data port gives access to all registers.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset, the level mask (address 0) reads 0x7F, the pulse mask (address 1) reads 0xFF, edge-select (address 2), both latched registers (addresses 4 and 5) and the pin mode (address 6) read 0, and irq_oe_o is low.
- R2: Status register (address 3, read only) bit i equals lvl_stat_i[i] as sampled at the most recent clock edge.
- R3: With edge-select bit i at 0, a 0-to-1 change of status bit i sets latched level bit i (address 4) at the following edge. A 1-to-0 change sets nothing.
- R4: With edge-select bit i at 1, either change of status bit i sets latched level bit i at the following edge.
- R5: A pls_evt_i bit that is high at a clock edge sets the matching latched pulse bit (address 5) at that edge.
- R6: Writing to address 4 or 5 clears each latched bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Latched bits otherwise hold.
- R7: If a set event and a clear write for the same latched bit fall on the same edge, the bit stays set.
- R8: The interrupt is active when any latched bit has its mask bit at 0. A mask bit of 1 keeps that source from the pin.
- R9: Pin mode with bit 0 equal to 0 (values 00 and 10) is open drain: irq_o is held at 0 and irq_oe_o is 1 exactly when the interrupt is active.
- R10: Pin mode 01 is push-pull active low: irq_oe_o is 1 and irq_o is the inverse of the interrupt state.
- R11: Pin mode 11 is push-pull active high: irq_oe_o is 1 and irq_o equals the interrupt state.
- R12: The register map is: 0 level mask [6:0], 1 pulse mask [7:0], 2 edge-select [6:0], 3 status, 4 latched level, 5 latched pulse, 6 pin mode [1:0]. Address 7 reads 0. Writes to addresses 3 and 7 have no effect, and unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvl_stat_i | input | 7 | Real-time level conditions |
| pls_evt_i | input | 8 | One-cycle event strobes |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt pin data value |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
A wrong edge-detector state shows up as an unexpected latched bit at address 4. Because the pin follows the latches in the same cycle, it also shows up as a pin change one edge after the registered status moves. A lost or stuck latch, or a clear that wins over a simultaneous event, changes the read of address 4 or 5 and the pin state in the cycle right after the edge concerned. Mask or mode register faults show at once as a wrong pin level or output enable, so comparing every cycle against a behavioural model localises each fault to the edge that caused it.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  localparam int unsigned N_LVL  = 7;
  localparam int unsigned N_PLS  = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_LVL = 3'd0,
    A_MASK_PLS = 3'd1,
    A_EDGE_SEL = 3'd2,
    A_STATUS   = 3'd3,
    A_LAT_LVL  = 3'd4,
    A_LAT_PLS  = 3'd5,
    A_PIN_MODE = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_lvl_edge.sv
module irq_lvl_edge #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] both_i,
  output logic [N-1:0] stat_q_o,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] stat_q, stat_d1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      stat_d1 <= '0;
    end else begin
      stat_q  <= stat_i;
      stat_d1 <= stat_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    // rise always counts; fall only in both-edge mode
    assign evt_o[i] = both_i[i] ? (stat_q[i] ^ stat_d1[i]) : (stat_q[i] & ~stat_d1[i]);
  end

  assign stat_q_o = stat_q;
endmodule

// File: rtl/irq_w1c.sv
module irq_w1c #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_o <= '0;
    else         lat_o <= (lat_o & ~clr_i) | set_i;  // set wins
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic       active_i,
  input  logic [1:0] mode_i,
  output logic       irq_o,
  output logic       irq_oe_o
);
  always_comb begin
    if (!mode_i[0]) begin
      irq_o    = 1'b0;
      irq_oe_o = active_i;
    end else begin
      irq_oe_o = 1'b1;
      irq_o    = mode_i[1] ? active_i : ~active_i;
    end
  end
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import line_irq_pkg::*;
#(
  parameter int unsigned NL = N_LVL,
  parameter int unsigned NP = N_PLS,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] lvl_stat_i,
  input  logic [NP-1:0] pls_evt_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic          irq_oe_o
);
  logic [NL-1:0] mask_lvl, edge_sel, stat_q, lvl_evt, lat_lvl, clr_lvl;
  logic [NP-1:0] mask_pls, lat_pls, clr_pls;
  logic [1:0]    mode_q;
  logic          active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_lvl <= '1;
      mask_pls <= '1;
      edge_sel <= '0;
      mode_q   <= 2'b00;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_MASK_LVL: mask_lvl <= reg_wdata_i[NL-1:0];
        A_MASK_PLS: mask_pls <= reg_wdata_i[NP-1:0];
        A_EDGE_SEL: edge_sel <= reg_wdata_i[NL-1:0];
        A_PIN_MODE: mode_q   <= reg_wdata_i[1:0];
        default: ;
      endcase
    end
  end

  assign clr_lvl = (reg_wr_i && reg_addr_i == A_LAT_LVL) ? reg_wdata_i[NL-1:0] : '0;
  assign clr_pls = (reg_wr_i && reg_addr_i == A_LAT_PLS) ? reg_wdata_i[NP-1:0] : '0;

  irq_lvl_edge #(.N(NL)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .stat_i(lvl_stat_i), .both_i(edge_sel),
    .stat_q_o(stat_q), .evt_o(lvl_evt)
  );

  irq_w1c #(.N(NL)) u_lat_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(lvl_evt), .clr_i(clr_lvl), .lat_o(lat_lvl)
  );

  irq_w1c #(.N(NP)) u_lat_pls (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(pls_evt_i), .clr_i(clr_pls), .lat_o(lat_pls)
  );

  assign active = |(lat_lvl & ~mask_lvl) | |(lat_pls & ~mask_pls);

  irq_pin_drv u_pin (
    .active_i(active), .mode_i(mode_q), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_MASK_LVL: reg_rdata_o[NL-1:0] = mask_lvl;
      A_MASK_PLS: reg_rdata_o[NP-1:0] = mask_pls;
      A_EDGE_SEL: reg_rdata_o[NL-1:0] = edge_sel;
      A_STATUS:   reg_rdata_o[NL-1:0] = stat_q;
      A_LAT_LVL:  reg_rdata_o[NL-1:0] = lat_lvl;
      A_LAT_PLS:  reg_rdata_o[NP-1:0] = lat_pls;
      A_PIN_MODE: reg_rdata_o[1:0]    = mode_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/line_irq_ctrl_chk.sv
module line_irq_ctrl_chk #(
  parameter int unsigned NL = 7,
  parameter int unsigned NP = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NP-1:0] pls_evt_i,
  input logic [NL-1:0] lvl_evt,
  input logic [NL-1:0] lat_lvl,
  input logic [NP-1:0] lat_pls,
  input logic [NL-1:0] clr_lvl,
  input logic [NP-1:0] clr_pls,
  input logic [NL-1:0] mask_lvl,
  input logic [NP-1:0] mask_pls,
  input logic [1:0]    mode_q,
  input logic          irq_o,
  input logic          irq_oe_o
);
  // R3 R4 R7
  lvl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_evt != '0) |=> ((lat_lvl & $past(lvl_evt)) == $past(lvl_evt)));

  // R5 R7
  pls_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pls_evt_i != '0) |=> ((lat_pls & $past(pls_evt_i)) == $past(pls_evt_i)));

  // R6
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lat_lvl & $past(lat_lvl & ~clr_lvl)) == $past(lat_lvl & ~clr_lvl)));

  // R6
  pls_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lat_pls & $past(lat_pls & ~clr_pls)) == $past(lat_pls & ~clr_pls)));

  // R3
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lat_lvl & ~$past(lat_lvl | lvl_evt)) == '0));

  // R8
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_lvl == '1 && mask_pls == '1 && !mode_q[0]) |-> !irq_oe_o);

  // R9
  od_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[0] |-> !irq_o);

  // R10 R11
  pp_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[0] |-> irq_oe_o);
endmodule

bind line_irq_ctrl line_irq_ctrl_chk #(.NL(NL), .NP(NP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pls_evt_i(pls_evt_i), .lvl_evt(lvl_evt),
  .lat_lvl(lat_lvl), .lat_pls(lat_pls), .clr_lvl(clr_lvl), .clr_pls(clr_pls),
  .mask_lvl(mask_lvl), .mask_pls(mask_pls), .mode_q(mode_q),
  .irq_o(irq_o), .irq_oe_o(irq_oe_o)
);

// File: tb/line_irq_ctrl_test.sv
`timescale 1ns/1ps
module line_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] lvl = '0;
  logic [7:0] pls = '0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, irq_oe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  line_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .lvl_stat_i(lvl), .pls_evt_i(pls),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  // behavioural reference model
  logic [6:0] m_ml, m_es, m_sq, m_sd, m_ll;
  logic [7:0] m_mp, m_lp;
  logic [1:0] m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ml <= 7'h7F; m_mp <= 8'hFF; m_es <= '0; m_mode <= '0;
      m_sq <= '0; m_sd <= '0; m_ll <= '0; m_lp <= '0;
    end else begin
      logic [6:0] ev, cl;
      logic [7:0] cp;
      cl = '0; cp = '0;
      for (int i = 0; i < 7; i++) begin
        if (m_es[i]) ev[i] = (m_sq[i] != m_sd[i]);
        else         ev[i] = (m_sq[i] == 1'b1 && m_sd[i] == 1'b0);
      end
      if (wr) begin
        if (addr == 3'd0) m_ml <= wdata[6:0];
        if (addr == 3'd1) m_mp <= wdata;
        if (addr == 3'd2) m_es <= wdata[6:0];
        if (addr == 3'd4) cl = wdata[6:0];
        if (addr == 3'd5) cp = wdata;
        if (addr == 3'd6) m_mode <= wdata[1:0];
      end
      m_ll <= (m_ll & ~cl) | ev;
      m_lp <= (m_lp & ~cp) | pls;
      m_sd <= m_sq;
      m_sq <= lvl;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_ml};
      3'd1: return m_mp;
      3'd2: return {1'b0, m_es};
      3'd3: return {1'b0, m_sq};
      3'd4: return {1'b0, m_ll};
      3'd5: return m_lp;
      3'd6: return {6'b0, m_mode};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic act;
      logic [1:0] e;
      string rt;
      act = ((m_ll & ~m_ml) != 0) || ((m_lp & ~m_mp) != 0);
      if (!m_mode[0])     e = {1'b0, act};
      else if (!m_mode[1]) e = {~act, 1'b1};
      else                 e = {act, 1'b1};
      if (!m_mode[0])      chk("R8 R9 pin", {6'b0, irq, irq_oe}, {6'b0, e});
      else if (!m_mode[1]) chk("R8 R10 pin", {6'b0, irq, irq_oe}, {6'b0, e});
      else                 chk("R8 R11 pin", {6'b0, irq, irq_oe}, {6'b0, e});
      case (addr)
        3'd0, 3'd1: rt = "R12 mask read";
        3'd2: rt = "R4 edge-select read";
        3'd3: rt = "R2 status read";
        3'd4: rt = "R3 R6 R7 latched level read";
        3'd5: rt = "R5 R6 R7 latched pulse read";
        default: rt = "R12 map read";
      endcase
      chk(rt, rdata, exp_rd(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    step(); addr = a; wdata = d; wr = 1'b1;
    step(); wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      step(); addr = 3'(k);
    end
  endtask

  task automatic rd_at(input logic [2:0] a, input string tag, input logic [7:0] exp);
    step(); addr = a; wr = 1'b0;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // reset values
    rd_at(3'd0, "R1 level mask reset", 8'h7F);
    rd_at(3'd1, "R1 pulse mask reset", 8'hFF);
    rd_at(3'd2, "R1 edge-select reset", 8'h00);
    rd_at(3'd4, "R1 latched level reset", 8'h00);
    rd_at(3'd5, "R1 latched pulse reset", 8'h00);
    rd_at(3'd6, "R1 mode reset", 8'h00);
    chk("R1 oe reset", {7'b0, irq_oe}, 8'h00);

    // events while masked do not reach the pin
    step(); pls = 8'h01;
    step(); pls = 8'h00;
    idle(3);
    chk("R8 masked pulse pin", {7'b0, irq_oe}, 8'h00);
    wr_reg(3'd5, 8'hFF);

    // rising-only mode
    wr_reg(3'd0, 8'h00);
    wr_reg(3'd6, 8'h03);
    step(); lvl = 7'h05;
    idle(4);
    rd_at(3'd4, "R3 rise sets latch", 8'h05);
    wr_reg(3'd4, 8'h01);
    rd_at(3'd4, "R6 partial clear", 8'h04);
    wr_reg(3'd4, 8'h04);
    step(); lvl = 7'h00;
    idle(4);
    rd_at(3'd4, "R3 fall ignored", 8'h00);

    // both-edge mode
    wr_reg(3'd2, 8'h7F);
    step(); lvl = 7'h40;
    idle(3);
    wr_reg(3'd4, 8'h7F);
    step(); lvl = 7'h00;
    idle(4);
    rd_at(3'd4, "R4 fall sets latch", 8'h40);
    wr_reg(3'd4, 8'h7F);

    // pulses and clear collision
    step(); pls = 8'hA5;
    step(); pls = 8'h00;
    rd_at(3'd5, "R5 pulse latch", 8'hA5);
    step(); pls = 8'h01; addr = 3'd5; wdata = 8'hFF; wr = 1'b1;
    step(); pls = 8'h00; wr = 1'b0;
    rd_at(3'd5, "R7 set beats clear", 8'h01);

    // pin modes
    wr_reg(3'd6, 8'h01);
    idle(2);
    wr_reg(3'd6, 8'h00);
    idle(2);
    wr_reg(3'd6, 8'h02);
    idle(2);
    wr_reg(3'd5, 8'hFF);
    idle(2);

    // writes to read-only and unused addresses
    wr_reg(3'd3, 8'hFF);
    wr_reg(3'd7, 8'hFF);
    rd_at(3'd3, "R12 status unwritable", 8'h00);
    rd_at(3'd7, "R12 unused reads zero", 8'h00);

    // mixed random traffic
    for (int k = 0; k < 2000; k++) begin
      step();
      lvl   = 7'($urandom);
      pls   = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      addr  = 3'($urandom);
      wdata = 8'($urandom);
      wr    = ($urandom % 3 == 0);
    end
    step(); wr = 1'b0;
    idle(8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule